// File: doc/BRIEF.md
# MSI-X Vector Engine

This block is the interrupt half of a message-signalled interrupt capability with per-vector programming. It keeps a table of vector entries. Each entry holds a 64-bit message address, 32-bit message data and a per-vector mask. It also keeps a pending-bit array and two control bits: a global enable and a function-wide mask. Device logic raises interrupts by vector number. The block turns each request into an address/data pair on a valid/ready output, or parks it as pending when the vector is masked.

Software reaches the table and the pending array through one 32-bit read/write bus. A window-select bit chooses between the two regions. A parked interrupt is sent automatically once its vector becomes unmasked. This happens when the per-vector mask is cleared by a table write, or when the function mask drops. A function-mask drop starts a rescan that visits one vector per clock. Device logic also keeps a use count per vector. A vector with no users never delivers.

Top module: `msix_vector_engine`

## Requirements
- R1: After reset, the block is in this state:
  - every table word reads zero, except the vector-control word, which reads 1 (masked);
  - the pending array reads zero;
  - the function mask is active, because enable is clear.
- R2: A request is dropped with no message and no pending bit when either of these holds:
  - `irq_vec` is at or above NUM_VEC;
  - the vector's use count is zero.
- R3: An accepted request on an unmasked vector produces one message. Its `msg_addr` is {address-high word, address-low word} and its `msg_data` is the data word of that entry. `msg_valid`, `msg_addr` and `msg_data` hold steady until `msg_ready` is high.
- R4: A request on a masked vector sets its pending bit and sends nothing. A vector is masked when its own mask bit is set, when enable is clear, or when mask-all is set.
- R5: Table layout:
  - entry v starts at byte address 16*v;
  - word offset 0 is the address low word, 4 is the address high word, 8 is the data word, and 12 is vector control;
  - vector control has the mask in bit 0, and its other bits read as zero.
- R6: Suppose a vector-control write moves a vector from masked to unmasked while its pending bit is set. The pending bit clears and the stored message is sent. A control write that leaves the mask state unchanged sends nothing.
- R7: Pending-window layout and access:
  - vector v's pending bit is bit v mod 32 of word v/32 (byte v/8, bit v mod 8);
  - words past the last vector read zero;
  - bus writes to this window change nothing.
- R8: Behaviour of a control write:
  - a control write with enable set pulses `intx_clr` in the next cycle, and one without enable does not pulse it;
  - if enable is set and the function mask changes, every vector is rescanned;
  - during the rescan and any replays that follow, `irq_ready` is low;
  - parked interrupts on vectors that are now unmasked are sent in ascending vector order.
- R9: Use counts:
  - `use_req` increments a vector's use count;
  - `unuse_req` decrements it only when it is nonzero;
  - when the count reaches zero, the vector's pending bit is cleared.
- R10: A bus read returns `bus_rdata` with `bus_rvalid` high in the cycle after the request is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Strobe to load the control bits |
| ctrl_enable | input | 1 | New global enable value |
| ctrl_maskall | input | 1 | New function-wide mask value |
| intx_clr | output | 1 | One-cycle request to drop the legacy wire interrupt |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_pba | input | 1 | 1 = pending window, 0 = table window |
| bus_addr | input | clog2(NUM_VEC)+4 | Byte address inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| bus_rvalid | output | 1 | Read data valid |
| irq_req | input | 1 | Interrupt request strobe |
| irq_vec | input | clog2(NUM_VEC)+1 | Requested vector number |
| irq_ready | output | 1 | Request accepted when high |
| use_req | input | 1 | Add one user to `use_vec` |
| unuse_req | input | 1 | Remove one user from `use_vec` |
| use_vec | input | clog2(NUM_VEC)+1 | Vector for the use/unuse request |
| msg_valid | output | 1 | Message write available |
| msg_ready | input | 1 | Consumer takes the message |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The assertions rely on these properties of the inputs:
- the consumer never needs `msg_valid` to drop by itself;
- `irq_req` is only raised for a vector once the bench has seen `irq_ready` high;
- a bus read and a control write never depend on each other within one cycle.

The stimulus holds each strobe for exactly one clock and checks `irq_ready` before raising a request. It waits a fixed number of quiet cycles after each action, so every message, rescan and replay has drained before the next check. The vector sweeps cover all eight entries of the default configuration.

// File: rtl/msix_pkg.sv
package msix_pkg;
  typedef enum logic [1:0] {
    SLOT_ADDR_LO = 2'd0,
    SLOT_ADDR_HI = 2'd1,
    SLOT_DATA    = 2'd2,
    SLOT_VCTRL   = 2'd3
  } slot_e;

  localparam int WORD_W     = 32;
  localparam int RAM_LANES  = 3;
endpackage

// File: rtl/msix_lane_ram.sv
module msix_lane_ram #(
  parameter int DEPTH = 8,
  parameter int AW    = 3,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] a_addr,
  output logic [DW-1:0] a_q,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_q
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    a_q <= mem[a_addr];
    b_q <= mem[b_addr];
  end
endmodule

// File: rtl/msix_pick_lowest.sv
module msix_pick_lowest #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/msix_vector_engine.sv
module msix_vector_engine
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int CNT_W   = 4,
  localparam int VEC_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
  localparam int REQ_W  = VEC_W + 1,
  localparam int ADDR_W = VEC_W + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic              ctrl_enable,
  input  logic              ctrl_maskall,
  output logic              intx_clr,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_pba,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic              irq_req,
  input  logic [REQ_W-1:0]  irq_vec,
  output logic              irq_ready,
  input  logic              use_req,
  input  logic              unuse_req,
  input  logic [REQ_W-1:0]  use_vec,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [63:0]       msg_addr,
  output logic [31:0]       msg_data
);
  localparam logic [REQ_W-1:0] NV_LIM = REQ_W'(NUM_VEC);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic en_q, ma_q, fmask;
  logic [NUM_VEC-1:0] vmask_q, pend_q, fire_q, vmask_n, pend_n, fire_n;
  logic [NUM_VEC-1:0] seen_q [RAM_LANES];
  logic [CNT_W-1:0]   cnt_q [NUM_VEC];
  logic               scan_q;
  logic [VEC_W-1:0]   scan_idx_q;
  logic               load_q, valid_q, intx_q;
  logic [RAM_LANES-1:0] ld_seen_q, rd_seen_q;
  logic [63:0]        addr_q;
  logic [31:0]        data_q;
  logic [31:0]        ra_q [RAM_LANES];
  logic [31:0]        rb_q [RAM_LANES];

  assign fmask = !en_q || ma_q;

  // bus decode
  logic [1:0]       b_slot;
  logic [VEC_W-1:0] b_vec;
  logic             b_in, tab_wr, ctl_wr_hit;
  assign b_slot = bus_addr[3:2];
  assign b_vec  = bus_addr[ADDR_W-1:4];
  assign b_in   = {1'b0, b_vec} < NV_LIM;
  assign tab_wr = bus_valid && bus_write && !bus_pba && b_in;
  assign ctl_wr_hit = tab_wr && (slot_e'(b_slot) == SLOT_VCTRL);

  // request / replay arbitration
  logic             rep_any, rep_go, irq_take, irq_ok, cand_go, cand_used, send, park;
  logic [VEC_W-1:0] rep_vec, irq_idx, cand_vec, use_idx;
  logic             use_in;

  msix_pick_lowest #(.N(NUM_VEC), .IW(VEC_W)) pick_i (
    .req(fire_q), .any(rep_any), .idx(rep_vec));

  assign irq_idx   = irq_vec[VEC_W-1:0];
  assign use_idx   = use_vec[VEC_W-1:0];
  assign use_in    = use_vec < NV_LIM;
  assign irq_ready = !scan_q && !rep_any && !load_q && !valid_q;
  assign irq_take  = irq_req && irq_ready;
  assign irq_ok    = (irq_vec < NV_LIM) && (cnt_q[irq_idx] != '0);
  assign rep_go    = !scan_q && rep_any && !load_q && !valid_q;
  assign cand_go   = (irq_take && irq_ok) || rep_go;
  assign cand_vec  = irq_take ? irq_idx : rep_vec;
  assign cand_used = cnt_q[cand_vec] != '0;
  assign send      = cand_go && cand_used && !(fmask || vmask_q[cand_vec]);
  assign park      = cand_go && cand_used &&  (fmask || vmask_q[cand_vec]);

  // table storage: one RAM lane per data word of an entry
  for (genvar l = 0; l < RAM_LANES; l++) begin : g_lane
    msix_lane_ram #(.DEPTH(NUM_VEC), .AW(VEC_W), .DW(WORD_W)) ram_i (
      .clk(clk), .we(tab_wr && (b_slot == 2'(l))), .waddr(b_vec),
      .wdata(bus_wdata), .a_addr(b_vec), .a_q(ra_q[l]),
      .b_addr(cand_vec), .b_q(rb_q[l]));
  end

  // next-state of mask, pending and replay queues
  always_comb begin
    vmask_n = vmask_q;
    pend_n  = pend_q;
    fire_n  = fire_q;
    if (rep_go) fire_n[rep_vec] = 1'b0;
    if (park)   pend_n[cand_vec] = 1'b1;
    if (ctl_wr_hit) begin
      vmask_n[b_vec] = bus_wdata[0];
      if ((fmask || vmask_q[b_vec]) && !(fmask || bus_wdata[0]) && pend_q[b_vec]) begin
        pend_n[b_vec] = 1'b0;
        fire_n[b_vec] = 1'b1;
      end
    end
    if (scan_q && !fmask && !vmask_q[scan_idx_q] && pend_q[scan_idx_q]) begin
      pend_n[scan_idx_q] = 1'b0;
      fire_n[scan_idx_q] = 1'b1;
    end
    if (unuse_req && !use_req && use_in && cnt_q[use_idx] == CNT_W'(1))
      pend_n[use_idx] = 1'b0;
  end

  // pending-window read value
  logic [31:0] pba_word;
  always_comb begin
    pba_word = '0;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(i / 32)) pba_word[i % 32] = pend_q[i];
    end
  end

  // state registers
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0; ma_q <= 1'b0; intx_q <= 1'b0;
      scan_q <= 1'b0; scan_idx_q <= '0;
      vmask_q <= '1; pend_q <= '0; fire_q <= '0;
      for (int l = 0; l < RAM_LANES; l++) seen_q[l] <= '0;
      for (int v = 0; v < NUM_VEC; v++) cnt_q[v] <= '0;
    end else begin
      vmask_q <= vmask_n;
      pend_q  <= pend_n;
      fire_q  <= fire_n;
      intx_q  <= ctrl_wr && ctrl_enable;
      for (int l = 0; l < RAM_LANES; l++)
        if (tab_wr && b_slot == 2'(l)) seen_q[l][b_vec] <= 1'b1;
      if (use_req && use_in) begin
        if (cnt_q[use_idx] != CNT_MAX) cnt_q[use_idx] <= cnt_q[use_idx] + 1'b1;
      end else if (unuse_req && use_in && cnt_q[use_idx] != '0) begin
        cnt_q[use_idx] <= cnt_q[use_idx] - 1'b1;
      end
      if (scan_q) begin
        if (scan_idx_q == VEC_W'(NUM_VEC - 1)) scan_q <= 1'b0;
        scan_idx_q <= scan_idx_q + 1'b1;
      end
      if (ctrl_wr) begin
        en_q <= ctrl_enable;
        ma_q <= ctrl_maskall;
        if (ctrl_enable && (ctrl_maskall != fmask)) begin
          scan_q     <= 1'b1;
          scan_idx_q <= '0;
        end
      end
    end
  end

  // message output stage
  always_ff @(posedge clk) begin
    if (rst) begin
      load_q  <= 1'b0;
      valid_q <= 1'b0;
      ld_seen_q <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      load_q <= send;
      for (int l = 0; l < RAM_LANES; l++) ld_seen_q[l] <= seen_q[l][cand_vec];
      if (valid_q && msg_ready) valid_q <= 1'b0;
      if (load_q) begin
        valid_q <= 1'b1;
        addr_q  <= {rb_q[SLOT_ADDR_HI] & {32{ld_seen_q[SLOT_ADDR_HI]}},
                    rb_q[SLOT_ADDR_LO] & {32{ld_seen_q[SLOT_ADDR_LO]}}};
        data_q  <= rb_q[SLOT_DATA] & {32{ld_seen_q[SLOT_DATA]}};
      end
    end
  end

  // bus read return
  logic        rd_valid_q, rd_pba_q, rd_in_q, rd_mask_q;
  logic [1:0]  rd_slot_q;
  logic [31:0] rd_pba_val_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_q <= 1'b0; rd_pba_q <= 1'b0; rd_in_q <= 1'b0; rd_mask_q <= 1'b0;
      rd_slot_q <= '0; rd_pba_val_q <= '0; rd_seen_q <= '0;
    end else begin
      rd_valid_q   <= bus_valid && !bus_write;
      rd_pba_q     <= bus_pba;
      rd_in_q      <= b_in;
      rd_slot_q    <= b_slot;
      rd_mask_q    <= vmask_q[b_vec];
      rd_pba_val_q <= pba_word;
      for (int l = 0; l < RAM_LANES; l++) rd_seen_q[l] <= seen_q[l][b_vec];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_pba_q)                                bus_rdata = rd_pba_val_q;
    else if (!rd_in_q)                           bus_rdata = '0;
    else if (slot_e'(rd_slot_q) == SLOT_VCTRL)   bus_rdata = {31'd0, rd_mask_q};
    else if (rd_seen_q[rd_slot_q])               bus_rdata = ra_q[rd_slot_q];
  end

  assign bus_rvalid = rd_valid_q;
  assign intx_clr   = intx_q;
  assign msg_valid  = valid_q;
  assign msg_addr   = addr_q;
  assign msg_data   = data_q;
endmodule

// File: rtl/msix_vector_engine_chk.sv
module msix_vector_engine_chk (
  input logic        clk,
  input logic        rst,
  input logic        ctrl_wr,
  input logic        ctrl_enable,
  input logic        intx_clr,
  input logic        bus_valid,
  input logic        bus_write,
  input logic        bus_rvalid,
  input logic        irq_ready,
  input logic        msg_valid,
  input logic        msg_ready,
  input logic [63:0] msg_addr,
  input logic [31:0] msg_data
);
  a_r3_msg_hold: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  a_r8_busy_blocks_irq: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> !irq_ready);

  a_r8_intx_cause: assert property (@(posedge clk) disable iff (rst)
    intx_clr |-> $past(ctrl_wr && ctrl_enable));

  a_r8_intx_follows: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && ctrl_enable) |=> intx_clr);

  a_r10_read_latency: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> $past(bus_valid && !bus_write));
endmodule

bind msix_vector_engine msix_vector_engine_chk chk_i (
  .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_enable(ctrl_enable),
  .intx_clr(intx_clr), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_rvalid(bus_rvalid), .irq_ready(irq_ready), .msg_valid(msg_valid),
  .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data));

// File: tb/msix_vector_engine_tb_top.sv
module msix_vector_engine_tb_top;
  localparam int NV = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctrl_wr = 0, ctrl_enable = 0, ctrl_maskall = 0;
  logic intx_clr;
  logic bus_valid = 0, bus_write = 0, bus_pba = 0;
  logic [6:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_rvalid;
  logic irq_req = 0;
  logic [3:0] irq_vec = '0;
  logic irq_ready;
  logic use_req = 0, unuse_req = 0;
  logic [3:0] use_vec = '0;
  logic msg_valid, msg_ready = 1'b1;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;

  int errs = 0, checks = 0, got_n = 0, rd_ptr = 0;
  logic [63:0] got_addr [0:63];
  logic [31:0] got_data [0:63];

  always #10 clk = ~clk;

  msix_vector_engine #(.NUM_VEC(NV)) dut_i (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_enable(ctrl_enable),
    .ctrl_maskall(ctrl_maskall), .intx_clr(intx_clr), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_pba(bus_pba), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_ready(irq_ready),
    .use_req(use_req), .unuse_req(unuse_req), .use_vec(use_vec),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
    .msg_data(msg_data));

  always @(negedge clk) begin
    if (!rst && msg_valid && msg_ready) begin
      if (got_n < 64) begin
        got_addr[got_n] = msg_addr;
        got_data[got_n] = msg_data;
      end
      got_n++;
    end
  end

  function automatic logic [31:0] lo_of(int v); return 32'hFEE0_0000 | (v << 4); endfunction
  function automatic logic [31:0] hi_of(int v); return 32'h0000_00A0 + v; endfunction
  function automatic logic [31:0] dt_of(int v); return 32'h0000_0100 + v; endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic bus_wr(bit pba, int addr, logic [31:0] d);
    @(posedge clk); #1;
    bus_valid = 1; bus_write = 1; bus_pba = pba; bus_addr = 7'(addr); bus_wdata = d;
    @(posedge clk); #1;
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic bus_rd(bit pba, int addr, output logic [31:0] d);
    @(posedge clk); #1;
    bus_valid = 1; bus_write = 0; bus_pba = pba; bus_addr = 7'(addr);
    @(posedge clk); #1;
    bus_valid = 0;
    @(negedge clk);
    check("R10 read valid", 64'(bus_rvalid), 64'd1);
    d = bus_rdata;
  endtask

  task automatic pba_expect(logic [31:0] exp, string tag);
    logic [31:0] d;
    bus_rd(1'b1, 0, d);
    check(tag, 64'(d), 64'(exp));
  endtask

  task automatic ctrl(bit en, bit ma, bit exp_intx, bit exp_scan);
    @(posedge clk); #1;
    ctrl_wr = 1; ctrl_enable = en; ctrl_maskall = ma;
    @(posedge clk); #1;
    ctrl_wr = 0;
    @(negedge clk);
    check("R8 intx_clr pulse", 64'(intx_clr), 64'(exp_intx));
    check("R8 irq_ready during rescan", 64'(irq_ready), 64'(!exp_scan));
  endtask

  task automatic irq(int v);
    @(negedge clk);
    while (!irq_ready) @(negedge clk);
    @(posedge clk); #1;
    irq_req = 1; irq_vec = 4'(v);
    @(posedge clk); #1;
    irq_req = 0;
    tick(6);
  endtask

  task automatic use_op(bit up, int v);
    @(posedge clk); #1;
    use_req = up; unuse_req = !up; use_vec = 4'(v);
    @(posedge clk); #1;
    use_req = 0; unuse_req = 0;
  endtask

  task automatic exp_msg(int v, string tag);
    @(negedge clk);
    if (rd_ptr >= got_n) begin
      check({tag, " message missing"}, 64'(got_n), 64'(rd_ptr + 1));
    end else begin
      check({tag, " msg addr"}, got_addr[rd_ptr], {hi_of(v), lo_of(v)});
      check({tag, " msg data"}, 64'(got_data[rd_ptr]), 64'(dt_of(v)));
      rd_ptr++;
    end
  endtask

  task automatic exp_none(string tag);
    @(negedge clk);
    check({tag, " no message"}, 64'(got_n), 64'(rd_ptr));
    rd_ptr = got_n;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    tick(3); #1 rst = 0;
    @(negedge clk);
    check("R1 reset msg_valid", 64'(msg_valid), 64'd0);
    check("R1 reset irq_ready", 64'(irq_ready), 64'd1);
    // R1 and R5: reset image of every entry
    for (int v = 0; v < NV; v++) begin
      for (int w = 0; w < 4; w++) begin
        bus_rd(1'b0, v * 16 + w * 4, d);
        check($sformatf("R1 reset v%0d w%0d", v, w), 64'(d), (w == 3) ? 64'd1 : 64'd0);
      end
    end
    pba_expect(32'd0, "R1 reset pending");
    bus_rd(1'b1, 4, d);
    check("R7 pending word past vectors", 64'(d), 64'd0);

    // R5: program and read back the table
    for (int v = 0; v < NV; v++) begin
      bus_wr(1'b0, v * 16 + 0, lo_of(v));
      bus_wr(1'b0, v * 16 + 4, hi_of(v));
      bus_wr(1'b0, v * 16 + 8, dt_of(v));
      bus_wr(1'b0, v * 16 + 12, 32'hFFFF_FFFE);
    end
    for (int v = 0; v < NV; v++) begin
      bus_rd(1'b0, v * 16 + 0, d);  check("R5 addr low", 64'(d), 64'(lo_of(v)));
      bus_rd(1'b0, v * 16 + 4, d);  check("R5 addr high", 64'(d), 64'(hi_of(v)));
      bus_rd(1'b0, v * 16 + 8, d);  check("R5 data", 64'(d), 64'(dt_of(v)));
      bus_rd(1'b0, v * 16 + 12, d); check("R5 control", 64'(d), 64'd0);
    end
    exp_none("R1 unmask while disabled");

    // enable, users on vectors 0..6
    for (int v = 0; v < NV - 1; v++) use_op(1'b1, v);
    ctrl(1'b1, 1'b0, 1'b1, 1'b1);
    tick(14);
    exp_none("R8 rescan with nothing parked");

    // R3 / R2: delivery sweep
    for (int v = 0; v < NV; v++) begin
      irq(v);
      if (v < NV - 1) exp_msg(v, "R3 unmasked send");
      else            exp_none("R2 zero use count");
    end
    irq(8);  exp_none("R2 vector 8 out of range");
    irq(15); exp_none("R2 vector 15 out of range");
    pba_expect(32'd0, "R2 dropped leaves no pending");

    // R3: backpressure
    msg_ready = 0;
    irq(2);
    @(negedge clk);
    check("R3 held valid", 64'(msg_valid), 64'd1);
    check("R3 held addr", msg_addr, {hi_of(2), lo_of(2)});
    check("R3 held data", 64'(msg_data), 64'(dt_of(2)));
    exp_none("R3 not taken while ready low");
    @(posedge clk); #1 msg_ready = 1;
    tick(2);
    exp_msg(2, "R3 after ready");

    // R4 / R6 / R7: own mask
    bus_wr(1'b0, 3 * 16 + 12, 32'd1);
    irq(3);
    exp_none("R4 own mask parks");
    pba_expect(32'h08, "R4 pending bit 3");
    bus_wr(1'b1, 0, 32'd0);
    pba_expect(32'h08, "R7 pending write ignored");
    bus_wr(1'b0, 3 * 16 + 12, 32'd1);
    tick(6);
    exp_none("R6 unchanged mask");
    bus_wr(1'b0, 3 * 16 + 12, 32'd0);
    tick(8);
    exp_msg(3, "R6 unmask replays");
    pba_expect(32'd0, "R6 pending cleared");

    // R8: mask-all, rescan, ascending replay
    ctrl(1'b1, 1'b1, 1'b1, 1'b1);
    irq(5); irq(1); irq(4);
    exp_none("R4 mask-all parks");
    pba_expect(32'h32, "R4 pending 1,4,5");
    ctrl(1'b1, 1'b0, 1'b1, 1'b1);
    tick(40);
    exp_msg(1, "R8 replay order first");
    exp_msg(4, "R8 replay order second");
    exp_msg(5, "R8 replay order third");
    exp_none("R8 replay count");
    pba_expect(32'd0, "R8 pending drained");

    // R4 / R8: disabled
    ctrl(1'b0, 1'b0, 1'b0, 1'b0);
    irq(0);
    exp_none("R4 disabled parks");
    pba_expect(32'h01, "R4 pending bit 0");
    ctrl(1'b1, 1'b0, 1'b1, 1'b1);
    tick(20);
    exp_msg(0, "R8 enable replays");
    pba_expect(32'd0, "R8 pending cleared on enable");

    // R9: use counts
    use_op(1'b1, 6);
    bus_wr(1'b0, 6 * 16 + 12, 32'd1);
    irq(6);
    pba_expect(32'h40, "R9 parked with two users");
    use_op(1'b0, 6);
    pba_expect(32'h40, "R9 one user left keeps pending");
    use_op(1'b0, 6);
    pba_expect(32'h00, "R9 last user clears pending");
    use_op(1'b0, 6);
    bus_wr(1'b0, 6 * 16 + 12, 32'd0);
    tick(8);
    exp_none("R9 no replay after release");
    irq(6);
    exp_none("R2 released vector dropped");
    pba_expect(32'h00, "R2 released vector not parked");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule